// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block works out the column address for each beat of one SDRAM read or write burst. A controller gives it the registered mode word, the first column, a read/write flag and a one-cycle start strobe. From the next cycle on, the block drives one column address per cycle with a valid flag. It raises a done flag for a single cycle once a fixed-length burst has finished. A terminate strobe stops a burst early. It is the only way to stop a full-page burst.

Fixed bursts are 1, 2, 4 or 8 beats long and never leave the aligned group of columns that the length selects. The low bits of the first column set where the walk through that group begins. The walk is either sequential or interleaved. A full-page burst counts upward through the page, wraps to column 0 and keeps going. The mode word can also force every write to a single-location access while reads keep the programmed length.

The block issues no commands, counts no CAS latency and moves no data. The device data width is a parameter, and the column address width follows from it.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `col_valid` and `burst_done` are low.
- R2: Start is honoured only when the mode word is legal. The first beat then appears in the next cycle with `col_addr` equal to `start_col`. `col_valid` stays high for exactly the burst length: length code `mode_word[2:0]` values 0, 1, 2 and 3 give 1, 2, 4 and 8 beats.
- R3: With sequential type (`mode_word[3]`=0), beat k keeps the bits of `start_col` above the burst length, and its low bits are (start low bits + k) modulo the length.
- R4: With interleaved type (`mode_word[3]`=1), beat k keeps the upper bits, and its low bits are the start low bits XOR k.
- R5: Length code 7 with sequential type is full page. The address rises by one each cycle, wraps from the last column (1023 with the default 10-bit column) to 0, and continues until terminated.
- R6: When `mode_word[9]`=1, a write (`is_write`=1) is a single beat at `start_col`, and a read uses the programmed length.
- R7: A `term` pulse without `start` makes `col_valid` low in the next cycle, with no `burst_done`.
- R8: A legal start during a burst discards the old burst. The next cycle shows the first beat of the new one.
- R9: `burst_done` is high for exactly one cycle: the cycle after the last beat of a fixed-length burst. It never rises for a terminated or full-page burst.
- R10: A start with a reserved length code (4, 5, 6, or 7 with interleaved type) or with operating mode `mode_word[8:7]` not 00 is ignored. An idle block stays idle, and a running burst continues unchanged.
- R11: The CAS latency field `mode_word[6:4]` has no effect on the address sequence.
- R12: Each burst uses the mode word and `is_write` sampled at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_word | input | 10 | Registered mode word: length code, type, latency, operating mode, write burst mode |
| start_col | input | COL_W | First column of the burst |
| start | input | 1 | One-cycle burst start strobe |
| is_write | input | 1 | 1 for a write burst, 0 for a read |
| term | input | 1 | Terminate strobe |
| col_addr | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | High while a beat is presented |
| burst_done | output | 1 | One-cycle pulse after the last fixed-length beat |

## Verification
The checker watches four rules on every cycle: a burst can only begin from a start strobe, a terminate ends the burst with no completion pulse, the completion pulse lasts one cycle, and it never coincides with a valid beat. Other behaviour can only be seen through the bench's directed scenarios, each with its own expected addresses. This covers the address order inside the aligned group for both types and every length, the full-page wrap at the top of the page, single-beat writes, restarts, rejection of reserved modes and the indifference to the latency field.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

   localparam int MW_W = 10;

   // Decoded burst configuration, captured at each legal start
   typedef struct packed {
      logic       legal;
      logic       itl;
      logic       fullpage;
      logic [2:0] len_log;
   } burst_cfg_t;

   function automatic int col_bits(input int dq_w);
      return (dq_w == 16) ? 9 : (dq_w == 8) ? 10 : 11;
   endfunction

endpackage

// File: rtl/colgen_mode_dec.sv
module colgen_mode_dec
   import colgen_pkg::*;
(
   input  logic [MW_W-1:0] mode_word,
   input  logic            is_write,
   output burst_cfg_t      cfg
);
   logic [2:0] len_code;
   logic       itl_b;
   logic [1:0] op_mode;
   logic       wr_single;
   logic       code_ok;
   logic       unused_lat;

   assign len_code   = mode_word[2:0];
   assign itl_b      = mode_word[3];
   assign op_mode    = mode_word[8:7];
   assign wr_single  = is_write & mode_word[9];
   assign unused_lat = ^mode_word[6:4];

   assign code_ok = (len_code <= 3'd3) || ((len_code == 3'd7) && !itl_b);

   always_comb begin
      cfg          = '0;
      cfg.legal    = (op_mode == 2'b00) && code_ok;
      cfg.itl      = itl_b;
      cfg.fullpage = !wr_single && (len_code == 3'd7);
      cfg.len_log  = (wr_single || (len_code == 3'd7)) ? 3'd0 : len_code;
   end
endmodule

// File: rtl/colgen_seq.sv
module colgen_seq
   import colgen_pkg::*;
#(
   parameter int COL_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             term,
   input  burst_cfg_t       cfg_in,
   input  logic [COL_W-1:0] start_col,
   output logic             active,
   output logic             done,
   output logic [COL_W-1:0] base,
   output logic [COL_W-1:0] cnt,
   output burst_cfg_t       cfg_q
);
   logic [COL_W-1:0] last_cnt;
   logic             at_last;

   always_comb begin
      last_cnt      = '0;
      last_cnt[2:0] = 3'((4'd1 << cfg_q.len_log) - 4'd1);
   end

   assign at_last = !cfg_q.fullpage && (cnt == last_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         done   <= 1'b0;
         base   <= '0;
         cnt    <= '0;
         cfg_q  <= '0;
      end else begin
         done <= 1'b0;
         if (start && cfg_in.legal) begin
            active <= 1'b1;
            base   <= start_col;
            cnt    <= '0;
            cfg_q  <= cfg_in;
         end else if (term) begin
            active <= 1'b0;
         end else if (active) begin
            if (at_last) begin
               active <= 1'b0;
               done   <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/colgen_addr.sv
module colgen_addr
   import colgen_pkg::*;
#(
   parameter int COL_W = 10
) (
   input  logic [COL_W-1:0] base,
   input  logic [COL_W-1:0] cnt,
   input  burst_cfg_t       cfg,
   output logic [COL_W-1:0] addr
);
   localparam int GRP_BITS = 3;

   logic [COL_W-1:0] ord;

   assign ord = cfg.itl ? (base ^ cnt) : (base + cnt);

   for (genvar i = 0; i < COL_W; i++) begin : g_bit
      logic mask_b;
      if (i < GRP_BITS) begin : g_low
         assign mask_b = cfg.fullpage | (3'(i) < cfg.len_log);
      end else begin : g_high
         assign mask_b = cfg.fullpage;
      end
      assign addr[i] = mask_b ? ord[i] : base[i];
   end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
   import colgen_pkg::*;
#(
   parameter  int DQ_W  = 8,
   localparam int COL_W = col_bits(DQ_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [MW_W-1:0]  mode_word,
   input  logic [COL_W-1:0] start_col,
   input  logic             start,
   input  logic             is_write,
   input  logic             term,
   output logic [COL_W-1:0] col_addr,
   output logic             col_valid,
   output logic             burst_done
);
   if (!(DQ_W == 4 || DQ_W == 8 || DQ_W == 16)) begin : g_bad_dq
      $error("sdram_burst_colgen: DQ_W must be 4, 8 or 16");
   end

   burst_cfg_t       cfg_new;
   burst_cfg_t       cfg_cur;
   logic [COL_W-1:0] base_q;
   logic [COL_W-1:0] cnt_q;

   colgen_mode_dec u_dec (
      .mode_word (mode_word),
      .is_write  (is_write),
      .cfg       (cfg_new)
   );

   colgen_seq #(.COL_W(COL_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .term      (term),
      .cfg_in    (cfg_new),
      .start_col (start_col),
      .active    (col_valid),
      .done      (burst_done),
      .base      (base_q),
      .cnt       (cnt_q),
      .cfg_q     (cfg_cur)
   );

   colgen_addr #(.COL_W(COL_W)) u_addr (
      .base (base_q),
      .cnt  (cnt_q),
      .cfg  (cfg_cur),
      .addr (col_addr)
   );
endmodule

// File: rtl/colgen_chk.sv
module colgen_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic term,
   input logic col_valid,
   input logic burst_done
);
   // R2, R8: a burst only begins from a start strobe
   a_r2_valid_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(col_valid) |-> $past(start));

   // R7: terminate without start stops the burst quietly
   a_r7_term_stops: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(term) && !$past(start)) |-> (!col_valid && !burst_done));

   // R9: completion pulse lasts a single cycle
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      burst_done |=> !burst_done);

   // R9: completion never overlaps a valid beat
   a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      burst_done |-> !col_valid);
endmodule

bind sdram_burst_colgen colgen_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .term       (term),
   .col_valid  (col_valid),
   .burst_done (burst_done)
);

// File: tb/sdram_burst_colgen_bench.sv
module sdram_burst_colgen_bench;
   localparam int CW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [9:0]    mode_word = '0;
   logic [CW-1:0] start_col = '0;
   logic          start = 1'b0;
   logic          is_write = 1'b0;
   logic          term = 1'b0;
   logic [CW-1:0] col_addr;
   logic          col_valid;
   logic          burst_done;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   sdram_burst_colgen u_sdram_burst_colgen (
      .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .start_col(start_col),
      .start(start), .is_write(is_write), .term(term),
      .col_addr(col_addr), .col_valid(col_valid), .burst_done(burst_done)
   );

   function automatic logic [9:0] mw(int lenc, int itl, int cl, int opm, int wb);
      return {1'(wb), 2'(opm), 3'(cl), 1'(itl), 3'(lenc)};
   endfunction

   function automatic int exp_col(int s, int len, int itl, int k);
      int msk = len - 1;
      int low = itl ? (s ^ k) : (s + k);
      return ((s & ~msk) | (low & msk)) & ((1 << CW) - 1);
   endfunction

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic do_start(logic [9:0] m, int col, bit wr);
      @(negedge clk);
      mode_word = m; start_col = CW'(col); is_write = wr; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // beats are checked from the negedge where beat 0 is visible
   task automatic run_fixed(string tag, logic [9:0] m, int col, bit wr, int len, int itl);
      do_start(m, col, wr);
      for (int k = 0; k < len; k++) begin
         chk({tag, " valid"}, int'(col_valid), 1);
         chk({tag, " addr"}, int'(col_addr), exp_col(col, len, itl, k));
         chk({tag, " no early done"}, int'(burst_done), 0);
         @(negedge clk);
      end
      chk({tag, " R2 ends"}, int'(col_valid), 0);
      chk({tag, " R9 done"}, int'(burst_done), 1);
      @(negedge clk);
      chk({tag, " R9 done one cycle"}, int'(burst_done), 0);
   endtask

   task automatic t_reset();
      chk("R1 valid in reset", int'(col_valid), 0);
      chk("R1 done in reset", int'(burst_done), 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk("R1 valid after reset", int'(col_valid), 0);
      chk("R1 done after reset", int'(burst_done), 0);
   endtask

   task automatic t_sequential();
      run_fixed("R2 R3 seq len8", mw(3, 0, 2, 0, 0), 'h2D5, 0, 8, 0);
      run_fixed("R2 R3 seq len4", mw(2, 0, 2, 0, 0), 'h00E, 0, 4, 0);
      run_fixed("R2 R3 seq len2", mw(1, 0, 2, 0, 0), 'h3FF, 0, 2, 0);
      run_fixed("R2 seq len1", mw(0, 0, 2, 0, 0), 'h155, 0, 1, 0);
   endtask

   task automatic t_interleaved();
      run_fixed("R4 itl len8", mw(3, 1, 2, 0, 0), 'h1A3, 0, 8, 1);
      run_fixed("R4 itl len4", mw(2, 1, 2, 0, 0), 'h0B6, 0, 4, 1);
   endtask

   task automatic t_latency_field();
      run_fixed("R11 seq len8 lat3", mw(3, 0, 3, 0, 0), 'h2D5, 0, 8, 0);
      run_fixed("R11 itl len8 lat7", mw(3, 1, 7, 0, 0), 'h1A3, 0, 8, 1);
   endtask

   task automatic t_write_single();
      run_fixed("R6 write single", mw(3, 0, 2, 0, 1), 'h2D5, 1, 1, 0);
      run_fixed("R6 read keeps length", mw(3, 0, 2, 0, 1), 'h2D5, 0, 8, 0);
      run_fixed("R6 write full length", mw(2, 1, 2, 0, 0), 'h0B6, 1, 4, 1);
   endtask

   task automatic t_fullpage();
      do_start(mw(7, 0, 2, 0, 0), 'h3FC, 0);
      for (int k = 0; k < 8; k++) begin
         chk("R5 full page valid", int'(col_valid), 1);
         chk("R5 full page addr wraps", int'(col_addr), (('h3FC + k) & 'h3FF));
         chk("R9 no done in full page", int'(burst_done), 0);
         if (k < 7) @(negedge clk);
      end
      term = 1'b1;
      @(negedge clk);
      term = 1'b0;
      chk("R7 full page terminated", int'(col_valid), 0);
      chk("R9 no done after term", int'(burst_done), 0);
      @(negedge clk);
      chk("R9 still no done", int'(burst_done), 0);
   endtask

   task automatic t_terminate();
      do_start(mw(3, 0, 2, 0, 0), 'h040, 0);
      chk("R7 beat0", int'(col_addr), 'h040);
      @(negedge clk);
      chk("R7 beat1", int'(col_addr), 'h041);
      term = 1'b1;
      @(negedge clk);
      term = 1'b0;
      chk("R7 valid after term", int'(col_valid), 0);
      chk("R7 no done after term", int'(burst_done), 0);
      @(negedge clk);
      chk("R7 stays idle", int'(col_valid), 0);
      chk("R9 no late done", int'(burst_done), 0);
   endtask

   task automatic t_restart();
      do_start(mw(3, 0, 2, 0, 0), 'h010, 0);
      for (int k = 0; k < 3; k++) begin
         chk("R8 old beat", int'(col_addr), 'h010 + k);
         if (k < 2) @(negedge clk);
      end
      mode_word = mw(2, 0, 2, 0, 0); start_col = CW'('h205); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 4; k++) begin
         chk("R8 new beat valid", int'(col_valid), 1);
         chk("R8 new beat addr", int'(col_addr), exp_col('h205, 4, 0, k));
         @(negedge clk);
      end
      chk("R8 new burst length", int'(col_valid), 0);
      chk("R9 done of new burst", int'(burst_done), 1);
   endtask

   task automatic t_reserved();
      do_start(mw(5, 0, 2, 0, 0), 'h100, 0);
      chk("R10 code5 ignored", int'(col_valid), 0);
      do_start(mw(7, 1, 2, 0, 0), 'h100, 0);
      chk("R10 code7 itl ignored", int'(col_valid), 0);
      do_start(mw(3, 0, 2, 1, 0), 'h100, 0);
      chk("R10 op mode ignored", int'(col_valid), 0);
      chk("R10 no done", int'(burst_done), 0);
      // reserved start during a burst leaves it running
      do_start(mw(2, 0, 2, 0, 0), 'h040, 0);
      chk("R10 beat0", int'(col_addr), 'h040);
      mode_word = mw(4, 0, 2, 0, 0); start_col = CW'('h3FF); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 1; k < 4; k++) begin
         chk("R10 burst continues", int'(col_addr), 'h040 + k);
         @(negedge clk);
      end
      chk("R10 done after kept burst", int'(burst_done), 1);
   endtask

   task automatic t_sampled_mode();
      do_start(mw(2, 1, 2, 0, 0), 'h0B6, 0);
      mode_word = mw(0, 0, 0, 0, 1); is_write = 1'b1;
      for (int k = 0; k < 4; k++) begin
         chk("R12 mode held from start", int'(col_addr), exp_col('h0B6, 4, 1, k));
         @(negedge clk);
      end
      chk("R12 length held", int'(burst_done), 1);
      is_write = 1'b0;
   endtask

   initial begin
      t_reset();
      t_sequential();
      t_interleaved();
      t_latency_field();
      t_write_single();
      t_fullpage();
      t_terminate();
      t_restart();
      t_reserved();
      t_sampled_mode();
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule